// File: doc/BRIEF.md
# Five-State Snooping Coherence Line Controller

This block holds the coherence state and address tag for each line of a direct-mapped, write-back cache that shares a snooping bus with other caches and with a DMA engine. Each line is in one of five states. Invalid means absent. Clean-exclusive means the line matches memory and no other cache holds it. Owned-exclusive means the line is dirty and held only here. Clean-shared means other copies may exist and this cache has not modified the line. Owned-shared means the line is dirty, clean copies may exist elsewhere, and this cache answers for the data instead of memory.

Each cycle the block handles one event. The event is either a snooped bus transaction or a CPU request (read, write or evict). A snooped transaction takes priority. For a CPU request the block looks up the line and chooses the bus transaction to issue, all in the same cycle. The choice depends only on the stored state. The shared-line input reports whether another cache answered the transaction. It is sampled at the clock edge that ends the cycle, and it affects only the new state. For a snoop the block decides whether this cache must supply the data cache-to-cache and so override memory. It also computes the new state. The data array, bus arbitration and memory are outside this block.

Code values: CPU ops are read=0, write=1, evict=2 and idle=3. Bus ops are coherent read=0, read-and-invalidate=1, invalidate=2, block write-back=3 and DMA write-and-invalidate=4. States are invalid=0, clean-exclusive=1, owned-exclusive=2, clean-shared=3 and owned-shared=4. An address splits into the set index (low log2(SETS) bits) and the tag (the remaining bits). A line hits when its stored state is not invalid and its stored tag equals the address tag.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is invalid: `cpu_state` reads 0 for any address, and `bus_valid` and `intervene` are 0 while no request is presented.
- R2: A CPU read (op 0) that misses issues coherent read (bus op 0) in the same cycle. The line becomes clean-exclusive (1) if `other_cached` was 0 at the edge, and clean-shared (3) if it was 1. The new tag is stored.
- R3: A CPU write (op 1) that misses issues read-and-invalidate (bus op 1), and the line becomes owned-exclusive (2).
- R4: A CPU write that hits in clean-shared or owned-shared issues invalidate (bus op 2) and the line becomes owned-exclusive. A write hit in clean-exclusive moves to owned-exclusive with no bus transaction. A write hit in owned-exclusive issues nothing and keeps the state.
- R5: A CPU read hit issues no bus transaction and leaves the state unchanged.
- R6: A CPU evict (op 2) that hits an owned line issues block write-back (bus op 3). An evict that hits a clean line issues nothing. Both leave the line invalid. An evict that misses issues nothing and changes nothing.
- R7: A snooped coherent read that hits moves clean-exclusive to clean-shared and owned-exclusive to owned-shared, and leaves clean-shared and owned-shared unchanged. `intervene` is 1 in that cycle exactly when the line is owned (2 or 4). Owned-shared is entered by no other path.
- R8: A snooped read-and-invalidate that hits makes the line invalid. `intervene` is 1 in that cycle if the line was owned.
- R9: A snooped invalidate or DMA write-and-invalidate that hits makes the line invalid and never raises `intervene`.
- R10: A snooped block write-back, a snooped op code above 4, and any snoop that misses (invalid line or different tag) change no state and raise no `intervene`.
- R11: `bus_valid` and `bus_op` depend only on the request and the stored line. The `other_cached` value changes neither of them, and it affects the new state only on a read miss.
- R12: When `snp_valid` and `cpu_valid` are both 1, only the snoop is acted on. No bus transaction is issued and the CPU request changes no line.
- R13: A CPU read or write miss to a set that holds a valid line with another tag replaces that entry. The old address then reads invalid, and no write-back is issued for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | CPU request present |
| cpu_op | input | 2 | CPU op: 0 read, 1 write, 2 evict, 3 idle |
| cpu_addr | input | ADDR_W | CPU line address |
| snp_valid | input | 1 | Snooped bus transaction present |
| snp_op | input | 3 | Snooped bus op code |
| snp_addr | input | ADDR_W | Snooped line address |
| other_cached | input | 1 | Another cache holds the line; sampled at the edge that ends the transaction |
| bus_valid | output | 1 | This cache issues a bus transaction this cycle |
| bus_op | output | 3 | Bus op code being issued |
| intervene | output | 1 | Supply data cache-to-cache for the current snoop |
| cpu_state | output | 3 | State of the line at `cpu_addr` (0 when it misses) |

## Verification
The bench builds the controller with a 4-bit address and four sets, which leaves two tag bits per set. With so few sets, random traffic keeps hitting the same lines. Snoops from other caches therefore meet lines in each of the five states, tag conflicts happen often, and random CPU and snoop requests collide in the same cycle. Directed sequences drive each line through the complete owned-exclusive to owned-shared path and through the replacement path. Random steps then compare the bus op, the intervention flag and the looked-up state against a reference model kept in the bench.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [2:0] {
    ST_INV    = 3'd0,
    ST_CLN_EX = 3'd1,
    ST_OWN_EX = 3'd2,
    ST_CLN_SH = 3'd3,
    ST_OWN_SH = 3'd4
  } line_st_t;

  typedef enum logic [1:0] {
    CPU_RD    = 2'd0,
    CPU_WR    = 2'd1,
    CPU_EVICT = 2'd2,
    CPU_IDLE  = 2'd3
  } cpu_op_t;

  typedef enum logic [2:0] {
    BUS_RD     = 3'd0,
    BUS_RDINV  = 3'd1,
    BUS_INV    = 3'd2,
    BUS_WB     = 3'd3,
    BUS_DMAINV = 3'd4
  } bus_op_t;

  function automatic logic st_owned(line_st_t s);
    return (s == ST_OWN_EX) || (s == ST_OWN_SH);
  endfunction

endpackage

// File: rtl/coh_tag_array.sv
module coh_tag_array
  import coh_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int TAG_W = 5,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] a_idx,
  output logic [TAG_W-1:0] a_tag,
  output line_st_t         a_st,
  input  logic [IDX_W-1:0] b_idx,
  output logic [TAG_W-1:0] b_tag,
  output line_st_t         b_st,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  line_st_t         wr_st
);

  logic [TAG_W-1:0] tag_q [SETS];
  line_st_t         st_q  [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        st_q[s]  <= ST_INV;
        tag_q[s] <= '0;
      end
    end else if (wr_en) begin
      st_q[wr_idx]  <= wr_st;
      tag_q[wr_idx] <= wr_tag;
    end
  end

  assign a_tag = tag_q[a_idx];
  assign a_st  = st_q[a_idx];
  assign b_tag = tag_q[b_idx];
  assign b_st  = st_q[b_idx];

endmodule

// File: rtl/coh_fsm.sv
module coh_fsm
  import coh_pkg::*;
(
  input  logic     snoop_go,
  input  logic     cpu_go,
  input  logic     hit,
  input  line_st_t cur_st,
  input  cpu_op_t  cpu_op,
  input  logic [2:0] snp_op,
  input  logic     shared_in,
  output logic     bus_valid,
  output bus_op_t  bus_op,
  output logic     intervene,
  output logic     upd,
  output line_st_t nxt_st
);

  always_comb begin
    bus_valid = 1'b0;
    bus_op    = BUS_RD;
    intervene = 1'b0;
    upd       = 1'b0;
    nxt_st    = cur_st;
    if (snoop_go) begin
      if (hit) begin
        case (snp_op)
          3'd0: begin
            intervene = st_owned(cur_st);
            upd       = 1'b1;
            if (cur_st == ST_CLN_EX) nxt_st = ST_CLN_SH;
            if (cur_st == ST_OWN_EX) nxt_st = ST_OWN_SH;
          end
          3'd1: begin
            intervene = st_owned(cur_st);
            upd       = 1'b1;
            nxt_st    = ST_INV;
          end
          3'd2, 3'd4: begin
            upd    = 1'b1;
            nxt_st = ST_INV;
          end
          default: ;
        endcase
      end
    end else if (cpu_go) begin
      case (cpu_op)
        CPU_RD: if (!hit) begin
          bus_valid = 1'b1;
          bus_op    = BUS_RD;
          upd       = 1'b1;
          nxt_st    = shared_in ? ST_CLN_SH : ST_CLN_EX;
        end
        CPU_WR: begin
          upd    = 1'b1;
          nxt_st = ST_OWN_EX;
          if (!hit) begin
            bus_valid = 1'b1;
            bus_op    = BUS_RDINV;
          end else if (cur_st == ST_CLN_SH || cur_st == ST_OWN_SH) begin
            bus_valid = 1'b1;
            bus_op    = BUS_INV;
          end
        end
        CPU_EVICT: if (hit) begin
          upd    = 1'b1;
          nxt_st = ST_INV;
          if (st_owned(cur_st)) begin
            bus_valid = 1'b1;
            bus_op    = BUS_WB;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SETS   = 8,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic [1:0]        cpu_op,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              snp_valid,
  input  logic [2:0]        snp_op,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              other_cached,
  output logic              bus_valid,
  output logic [2:0]        bus_op,
  output logic              intervene,
  output logic [2:0]        cpu_state
);

  logic [IDX_W-1:0] c_idx, s_idx;
  logic [TAG_W-1:0] c_tag, s_tag, c_tag_q, s_tag_q;
  line_st_t         c_st, s_st, nxt_st, lk_st;
  logic             c_hit, s_hit, cpu_go, upd, lk_hit;
  bus_op_t          bus_op_e;

  assign c_idx = cpu_addr[IDX_W-1:0];
  assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];

  coh_tag_array #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_idx  (c_idx),
    .a_tag  (c_tag_q),
    .a_st   (c_st),
    .b_idx  (s_idx),
    .b_tag  (s_tag_q),
    .b_st   (s_st),
    .wr_en  (upd),
    .wr_idx (snp_valid ? s_idx : c_idx),
    .wr_tag (snp_valid ? s_tag : c_tag),
    .wr_st  (nxt_st)
  );

  assign c_hit  = (c_st != ST_INV) && (c_tag_q == c_tag);
  assign s_hit  = (s_st != ST_INV) && (s_tag_q == s_tag);
  assign cpu_go = cpu_valid && !snp_valid;
  assign lk_hit = snp_valid ? s_hit : c_hit;
  assign lk_st  = snp_valid ? s_st : c_st;

  coh_fsm u_fsm (
    .snoop_go  (snp_valid),
    .cpu_go    (cpu_go),
    .hit       (lk_hit),
    .cur_st    (lk_st),
    .cpu_op    (cpu_op_t'(cpu_op)),
    .snp_op    (snp_op),
    .shared_in (other_cached),
    .bus_valid (bus_valid),
    .bus_op    (bus_op_e),
    .intervene (intervene),
    .upd       (upd),
    .nxt_st    (nxt_st)
  );

  assign bus_op    = bus_op_e;
  assign cpu_state = c_hit ? c_st : ST_INV;

  // R7: owned-shared is written only over an owned-exclusive or owned-shared line
  a_r7_os_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && nxt_st == ST_OWN_SH) |-> (lk_st == ST_OWN_EX || lk_st == ST_OWN_SH));

  a_r7_intervene_owner: assert property (@(posedge clk) disable iff (!rst_n)
    intervene |-> (snp_valid && s_hit && st_owned(s_st)));

  a_r12_snoop_blocks_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !bus_valid);

  a_r4_inv_from_shared: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_op == BUS_INV) |-> (c_st == ST_CLN_SH || c_st == ST_OWN_SH));

  a_r6_wb_from_owned: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_op == BUS_WB) |-> st_owned(c_st));

  a_r3_write_leaves_owned: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cpu_go && cpu_op == CPU_WR) && cpu_addr == $past(cpu_addr))
      |-> cpu_state == ST_OWN_EX);

endmodule

// File: tb/sim_coh_line_ctrl.sv
module sim_coh_line_ctrl;

  localparam int AW = 4;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic cpu_valid, snp_valid, other_cached;
  logic [1:0] cpu_op;
  logic [2:0] snp_op;
  logic [AW-1:0] cpu_addr, snp_addr;
  logic bus_valid, intervene;
  logic [2:0] bus_op, cpu_state;

  int checks = 0;
  int errors = 0;
  int m_st [NS];
  int m_tag [NS];

  always #4 clk = ~clk;

  coh_line_ctrl #(.ADDR_W(AW), .SETS(NS)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_addr(cpu_addr),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
    .other_cached(other_cached),
    .bus_valid(bus_valid), .bus_op(bus_op), .intervene(intervene),
    .cpu_state(cpu_state)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int look(input int a);
    if (m_st[a % NS] != 0 && m_tag[a % NS] == a / NS) return m_st[a % NS];
    return 0;
  endfunction

  function automatic string req_of(input bit cv, input int cop, input bit sv,
                                   input int sop, input int st);
    if (sv && cv) return "R12";
    if (sv) begin
      if (st == 0 || sop == 3 || sop > 4) return "R10";
      if (sop == 0) return "R7";
      if (sop == 1) return "R8";
      return "R9";
    end
    if (!cv || cop == 3) return "R1";
    if (cop == 0) return (st == 0) ? "R2" : "R5";
    if (cop == 1) return (st == 0) ? "R3" : "R4";
    return "R6";
  endfunction

  task automatic step(input bit cv, input int cop, input int ca, input bit sv,
                      input int sop, input int sa, input bit sh, input string tag);
    int cst, sst, ebop, nst, idx;
    bit ebv, eiv, upd;
    string req;
    @(negedge clk);
    cpu_valid = cv; cpu_op = 2'(cop); cpu_addr = AW'(ca);
    snp_valid = sv; snp_op = 3'(sop); snp_addr = AW'(sa);
    other_cached = sh;
    #1;
    cst = look(ca); sst = look(sa);
    ebv = 0; ebop = 0; eiv = 0; upd = 0; nst = 0;
    if (sv) begin
      idx = sa % NS;
      if (sst != 0) begin
        if (sop == 0) begin
          eiv = (sst == 2 || sst == 4); upd = 1;
          nst = (sst == 1) ? 3 : (sst == 2) ? 4 : sst;
        end else if (sop == 1) begin
          eiv = (sst == 2 || sst == 4); upd = 1; nst = 0;
        end else if (sop == 2 || sop == 4) begin
          upd = 1; nst = 0;
        end
      end
    end else if (cv) begin
      idx = ca % NS;
      if (cop == 0 && cst == 0) begin
        ebv = 1; ebop = 0; upd = 1; nst = sh ? 3 : 1;
      end else if (cop == 1) begin
        upd = 1; nst = 2;
        if (cst == 0) begin ebv = 1; ebop = 1; end
        else if (cst == 3 || cst == 4) begin ebv = 1; ebop = 2; end
      end else if (cop == 2 && cst != 0) begin
        upd = 1; nst = 0;
        if (cst == 2 || cst == 4) begin ebv = 1; ebop = 3; end
      end
    end
    req = (tag == "") ? req_of(cv, cop, sv, sop, sv ? sst : cst) : tag;
    chk(req, "bus_valid", int'(bus_valid), int'(ebv));
    if (ebv) chk(req, "bus_op", int'(bus_op), ebop);
    chk(req, "intervene", int'(intervene), int'(eiv));
    chk(req, "cpu_state", int'(cpu_state), cst);
    if (upd) begin
      m_st[idx] = nst;
      m_tag[idx] = sv ? sa / NS : ca / NS;
    end
  endtask

  task automatic probe(input int a, input int exp, input string req);
    @(negedge clk);
    cpu_valid = 0; snp_valid = 0; cpu_addr = AW'(a);
    #1;
    chk(req, "cpu_state probe", int'(cpu_state), exp);
    chk(req, "idle bus_valid", int'(bus_valid), 0);
  endtask

  initial begin
    for (int i = 0; i < 120000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int dummy;
    dummy = $urandom(32'h5eed1234);
    for (int i = 0; i < NS; i++) begin m_st[i] = 0; m_tag[i] = 0; end
    rst_n = 0; cpu_valid = 0; snp_valid = 0; cpu_op = 0; snp_op = 0;
    cpu_addr = 0; snp_addr = 0; other_cached = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    for (int a = 0; a < 16; a++) probe(a, 0, "R1");

    step(1, 0, 1, 0, 0, 0, 0, "R2");       // read miss, not shared
    probe(1, 1, "R2");
    step(1, 0, 1, 0, 0, 0, 1, "R5");       // read hit
    probe(1, 1, "R11");                    // shared input ignored on hit
    step(0, 0, 1, 1, 0, 1, 0, "R7");       // CE snoops read
    probe(1, 3, "R7");
    step(1, 1, 1, 0, 0, 0, 0, "R4");       // CS write -> invalidate
    probe(1, 2, "R4");
    step(0, 0, 1, 1, 0, 1, 0, "R7");       // OE snoops read -> OS
    probe(1, 4, "R7");
    step(0, 0, 1, 1, 0, 1, 1, "R7");       // OS stays OS
    step(0, 0, 1, 1, 3, 1, 0, "R10");      // write-back not snooped
    step(0, 0, 1, 1, 0, 5, 0, "R10");      // tag miss
    probe(1, 4, "R10");
    step(1, 2, 1, 0, 0, 0, 0, "R6");       // evict owned
    probe(1, 0, "R6");
    step(1, 1, 2, 0, 0, 0, 1, "R3");       // write miss
    probe(2, 2, "R3");
    step(1, 1, 2, 0, 0, 0, 0, "R4");       // OE write silent
    step(0, 0, 2, 1, 1, 2, 0, "R8");       // RDINV on owned
    probe(2, 0, "R8");
    step(1, 0, 3, 0, 0, 0, 1, "R2");       // read miss shared
    probe(3, 3, "R2");
    step(1, 1, 3, 1, 4, 3, 0, "R12");      // DMA snoop + cpu write together
    probe(3, 0, "R9");
    step(1, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 1, 0, 0, 0, 0, 0, "R4");       // CE write silent -> OE
    step(1, 0, 4, 0, 0, 0, 0, "R13");      // conflict miss, no write-back
    probe(0, 0, "R13");
    probe(4, 1, "R13");
    step(0, 0, 4, 1, 2, 4, 0, "R9");       // CI on clean line
    probe(4, 0, "R9");

    for (int n = 0; n < 4000; n++) begin
      bit cv, sv;
      cv = ($urandom % 4) != 0;
      sv = ($urandom % 3) == 0;
      step(cv, int'($urandom % 4), int'($urandom % 16), sv, int'($urandom % 6),
           int'($urandom % 16), bit'($urandom % 2), "");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule